// File: doc/BRIEF.md
# Serial Transmitter with Selectable Line Polarity

This block is the transmit half of an asynchronous serial port. A byte enters a single-entry holding register through a valid/ready write port. On a baud tick it moves into a frame shifter that drives the line. The shifter sends a low start bit, eight data bits least significant first, an optional even or odd parity bit, and one or two high stop bits. Each bit lasts 16 baud ticks. The baud tick is a one-cycle enable that comes from outside the block. When a byte moves from the holding register into the shifter, a one-cycle interrupt pulse is issued and the buffer-full flag drops. The host can then write the next byte while the current frame is still being sent.

The write port has one back-pressure rule: `wr_ready` follows `tx_en`. While transmit is enabled, every write is accepted. A write that arrives while the holding register is still full replaces the waiting byte, so software polls `buf_full` if it must not lose data. While `tx_en` is low, writes are refused and have no effect.

A polarity select inverts every bit on the line. It also sets the fixed level that the line holds while transmit is disabled, after enable but before the first write, and while the low-power input is asserted. The low-power input also stops any frame in progress and holds back new frames.

Top module: `sertx_top`

## Requirements
- R1: In reset, `buf_full` and `tx_irq` are 0 and `txd` sits at the fixed level (1 when `inv_sel`=0).
- R2: `wr_ready` equals `tx_en`. An accepted write sets `buf_full` to 1 on the next cycle. A write offered while `tx_en`=0 changes nothing.
- R3: A frame starts on a clock where all of the following hold: `baud_tick`=1, the holding register is full, `tx_en`=1, `lowpwr`=0, and the shifter is idle or in the final tick of its last bit. On the next cycle `buf_full` is 0 (unless a new write landed in the same cycle) and `tx_irq` is 1 for exactly one cycle.
- R4: If a second byte is written before the held byte has moved to the shifter, only the second byte is transmitted.
- R5: The frame, in line time, is: start bit 0, then data bit 0 up to bit 7, then the parity bit if `par_en`=1, then stop bits of value 1 (two if `two_stop`=1, otherwise one). Each bit lasts 16 baud ticks, and the line returns to its idle level afterwards.
- R6: The parity bit makes the count of ones over the 8 data bits plus parity even when `par_odd`=0 and odd when `par_odd`=1.
- R7: When `inv_sel`=1, every bit of the frame appears inverted on `txd`.
- R8: `txd` equals NOT `inv_sel` in three cases: while `tx_en`=0, from enable until the first accepted write, and while `lowpwr`=1.
- R9: Dropping `tx_en` during a frame forces `txd` to its fixed level in that same cycle and empties the holding register. The aborted byte is never resumed.
- R10: While `lowpwr`=1, a frame in progress is abandoned, no frame starts and a held byte stays held. The byte is sent after `lowpwr` returns to 0.
- R11: A byte written while a frame is being sent starts on the tick that ends the previous frame's last stop bit, with no idle gap, and its `tx_irq` comes exactly 16×(frame bits) ticks after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| inv_sel | input | 1 | Line polarity select (1 = inverted line) |
| lowpwr | input | 1 | Low-power request; forces the line and halts frames |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| baud_tick | input | 1 | One-cycle oversampling tick (16 per bit) |
| wr_valid | input | 1 | Write request for the holding register |
| wr_ready | output | 1 | Write accepted (equals tx_en) |
| wr_data | input | 8 | Byte to send |
| buf_full | output | 1 | Holding register occupied |
| tx_irq | output | 1 | One-cycle pulse when a byte enters the shifter |
| txd | output | 1 | Serial line output |

## Verification
A bad bit counter or bad frame length is visible on `txd` within one bit time of the fault. It also moves the next `tx_irq` off the exact 16×N-tick spacing. A holding register that loses its full state or its latest byte shows at the ports in one of two ways: no interrupt pulse appears, or the wrong byte shows up in the next frame's data bits. A wrong parity or polarity path corrupts a single bit slot in every affected frame. For these reasons each frame is checked bit by bit at mid-bit, over all byte values and all sixteen framing and polarity combinations.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Per-frame framing choices, latched into the shifter at frame start.
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } sertx_cfg_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  // A write wins over a take: the shifter copies the old byte and the new one stays held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush) begin
      full_q <= 1'b0;
    end else if (wr_fire) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R2
  wr_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !flush) |=> full_q);

  // R4
  wr_replaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !flush) |=> (data_q == $past(wr_data)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  sertx_cfg_t        cfg,
  output logic              busy,
  output logic              finishing,
  output logic              line_bit
);

  localparam int FR_W  = DATA_W + 4;
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int CNT_W = $clog2(FR_W + 1);

  logic [FR_W-1:0]  sr_q;
  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic             busy_q;

  logic             par_bit;
  logic [FR_W-1:0]  frame_d;
  logic [CNT_W-1:0] last_d;
  logic             sub_wrap;

  always_comb begin
    par_bit = (^load_data) ^ cfg.par_odd;
    if (cfg.par_en) frame_d = {2'b11, par_bit, load_data, 1'b0};
    else            frame_d = {3'b111, load_data, 1'b0};
    last_d = CNT_W'(DATA_W + 1) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
  end

  assign sub_wrap  = (sub_q == SUB_W'(OVS - 1));
  assign finishing = busy_q && tick && sub_wrap && (cnt_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      sub_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sr_q   <= frame_d;
      sub_q  <= '0;
      cnt_q  <= '0;
      last_q <= last_d;
      busy_q <= 1'b1;
    end else if (abort) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
    end else if (busy_q && tick) begin
      if (sub_wrap) begin
        sub_q <= '0;
        if (cnt_q == last_q) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sr_q  <= {1'b1, sr_q[FR_W-1:1]};
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign line_bit = sr_q[0];

  // R5
  bit_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last_q));

  // R5
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !line_bit));

  // R9
  abort_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !load) |=> !busy_q);

endmodule

// File: rtl/sertx_line.sv
module sertx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic lowpwr,
  input  logic inv_sel,
  input  logic wr_fire,
  input  logic busy,
  input  logic line_bit,
  output logic txd
);

  logic started_q;
  logic forced;

  // Remembers that a byte has been written since the last enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       started_q <= 1'b0;
    else if (!tx_en)  started_q <= 1'b0;
    else if (wr_fire) started_q <= 1'b1;
  end

  assign forced = !tx_en || lowpwr || !started_q;
  assign txd    = (busy && !forced) ? (line_bit ^ inv_sel) : !inv_sel;

  // R8
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> started_q);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              inv_sel,
  input  logic              lowpwr,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              buf_full,
  output logic              tx_irq,
  output logic              txd
);

  sertx_cfg_t        cfg;
  logic              wr_fire;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              sh_busy;
  logic              sh_finishing;
  logic              sh_bit;
  logic              load;
  logic              halt;
  logic              irq_q;

  assign cfg      = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};
  assign wr_ready = tx_en;
  assign wr_fire  = wr_valid && wr_ready;
  assign halt     = !tx_en || lowpwr;
  assign load     = baud_tick && hold_full && !halt && (!sh_busy || sh_finishing);

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!tx_en),
    .wr_fire (wr_fire),
    .wr_data (wr_data),
    .take    (load),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (halt),
    .tick      (baud_tick),
    .load      (load),
    .load_data (hold_data),
    .cfg       (cfg),
    .busy      (sh_busy),
    .finishing (sh_finishing),
    .line_bit  (sh_bit)
  );

  sertx_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .lowpwr   (lowpwr),
    .inv_sel  (inv_sel),
    .wr_fire  (wr_fire),
    .busy     (sh_busy),
    .line_bit (sh_bit),
    .txd      (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= load;
  end

  assign tx_irq   = irq_q;
  assign buf_full = hold_full;

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R3
  start_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_fire) |=> !buf_full);

  // R10
  lowpwr_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr |=> !tx_irq);

  // R2
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en) |=> !buf_full);

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       inv_sel = 1'b0;
  logic       lowpwr = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       tick_on = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       baud_tick;
  logic       wr_ready;
  logic       buf_full;
  logic       tx_irq;
  logic       txd;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_seen = 0;

  assign baud_tick = tick_on;

  always #5 clk = ~clk;

  sertx_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .inv_sel   (inv_sel),
    .lowpwr    (lowpwr),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .two_stop  (two_stop),
    .baud_tick (baud_tick),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .buf_full  (buf_full),
    .tx_irq    (tx_irq),
    .txd       (txd)
  );

  always @(negedge clk) if (tx_irq) irq_seen++;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits();
    return 10 + int'(par_en) + int'(two_stop);
  endfunction

  // Expected line value of frame bit k for byte d under current pins.
  function automatic int exp_bit(input int k, input logic [7:0] d);
    int ones = 0;
    int b;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    if (k == 0)                 b = 0;
    else if (k <= 8)            b = int'(d[k-1]);
    else if (k == 9 && par_en)  b = par_odd ? (1 - ones % 2) : (ones % 2);
    else                        b = 1;
    return inv_sel ? 1 - b : b;
  endfunction

  task automatic do_write(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int ok = 0;
    for (int i = 0; i < 400; i++) begin
      if (tx_irq) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(req, ok, 1);
  endtask

  // Called on the negedge where tx_irq is first seen high.
  task automatic frame_check(input logic [7:0] d, input bit wb_en,
                             input logic [7:0] wb, input bit expect_next);
    int n = nbits();
    chk("R3 buf_full low at start", int'(buf_full), 0);
    if (wb_en) begin wr_valid = 1'b1; wr_data = wb; end
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R3 irq one cycle", int'(tx_irq), 0);
    chk("R11 buf_full during frame", int'(buf_full), int'(wb_en));
    repeat (7) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk($sformatf("R5 R6 R7 bit %0d of %02h", k, d), int'(txd), exp_bit(k, d));
      if (k < n - 1) repeat (16) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    if (expect_next) begin
      chk("R11 next irq without gap", int'(tx_irq), 1);
    end else begin
      chk("R5 idle after frame", int'(txd), inv_sel ? 0 : 1);
      chk("R5 no irq after frame", int'(tx_irq), 0);
    end
  endtask

  task automatic send(input logic [7:0] d);
    do_write(d);
    chk("R2 full after write", int'(buf_full), 1);
    wait_irq("R3 irq after write");
    frame_check(d, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 txd reset", int'(txd), 1);
    chk("R1 buf_full reset", int'(buf_full), 0);
    chk("R1 irq reset", int'(tx_irq), 0);
    chk("R2 ready when disabled", int'(wr_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: fixed level with inverted polarity, disabled and before first write
    inv_sel = 1'b1;
    #1 chk("R8 disabled inverted", int'(txd), 0);
    @(negedge clk);
    tx_en = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 before first write", int'(txd), 0);
    chk("R8 no frame before write", irq_seen, 0);

    // R2: writes refused while disabled
    tx_en = 1'b0;
    do_write(8'h55);
    chk("R2 refused write", int'(buf_full), 0);
    tx_en = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 no frame from refused write", irq_seen, 0);
    chk("R2 ready when enabled", int'(wr_ready), 1);

    // Sweep all byte values, even parity, one stop
    inv_sel = 1'b0; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
    for (int b = 0; b < 256; b++) send(8'(b));

    // Sweep every framing and polarity combination
    for (int c = 0; c < 16; c++) begin
      inv_sel = c[3]; par_en = c[2]; par_odd = c[1]; two_stop = c[0];
      for (int j = 0; j < 8; j++) begin
        int v = (j == 0) ? 0 : (j == 1) ? 255 : (j * 73 + c * 29) % 256;
        send(8'(v));
      end
    end

    // R4: overwrite before transfer
    inv_sel = 1'b0; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b1;
    tick_on = 1'b0;
    base = irq_seen;
    do_write(8'h3C);
    do_write(8'hC3);
    chk("R4 still full", int'(buf_full), 1);
    chk("R4 nothing started", irq_seen, base);
    tick_on = 1'b1;
    wait_irq("R4 irq");
    frame_check(8'hC3, 1'b0, 8'h00, 1'b0);

    // R11: back-to-back frames
    two_stop = 1'b0;
    do_write(8'hA5);
    wait_irq("R11 first irq");
    frame_check(8'hA5, 1'b1, 8'h5A, 1'b1);
    frame_check(8'h5A, 1'b0, 8'h00, 1'b0);

    // R9: disable mid-frame
    do_write(8'h00);
    wait_irq("R9 irq");
    repeat (40) @(negedge clk);
    chk("R9 mid-frame data low", int'(txd), 0);
    tx_en = 1'b0;
    #1 chk("R9 forced on disable", int'(txd), 1);
    @(negedge clk);
    tx_en = 1'b1;
    base = irq_seen;
    repeat (300) @(negedge clk);
    chk("R9 no resume", irq_seen, base);
    chk("R9 line stays fixed", int'(txd), 1);
    chk("R9 buffer emptied", int'(buf_full), 0);

    // R10: low power holds a byte back
    inv_sel = 1'b1;
    lowpwr = 1'b1;
    do_write(8'h81);
    base = irq_seen;
    repeat (100) @(negedge clk);
    chk("R10 no start in low power", irq_seen, base);
    chk("R10 line forced", int'(txd), 0);
    chk("R10 byte held", int'(buf_full), 1);
    lowpwr = 1'b0;
    wait_irq("R10 irq after release");
    frame_check(8'h81, 1'b0, 8'h00, 1'b0);

    // R10: low power aborts a frame
    do_write(8'h00);
    wait_irq("R10 irq");
    repeat (40) @(negedge clk);
    chk("R10 inverted data bit", int'(txd), 1);
    lowpwr = 1'b1;
    #1 chk("R10 forced mid-frame", int'(txd), 0);
    @(negedge clk);
    lowpwr = 1'b0;
    base = irq_seen;
    repeat (300) @(negedge clk);
    chk("R10 frame abandoned", irq_seen, base);
    chk("R10 line at fixed level", int'(txd), 0);

    summary();
    $finish;
  end

endmodule